// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block connects a synchronous on-chip requester to an external asynchronous static RAM. The memory has a 19-bit byte address, an 8-bit data bus and three active-low controls: chip select, output enable and write enable. The requester offers one byte access at a time with a valid/ready handshake. A read returns its byte with a one-cycle valid pulse. A write needs no response.

Each analog minimum of the memory is a parameter in nanoseconds. The sequencer rounds it up to whole clocks, using a clock-period parameter, and no phase is ever shorter than one clock. The sequencer then holds each strobe pattern for that many cycles. The bidirectional data bus is split into an output byte, an output-enable and an input byte, for a pad cell outside the block. The sequencer drives the bus only while a write is in progress.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset, and in every cycle with no access in progress, chip select, output enable and write enable are all high, the data bus is not driven, and `req_ready` is 1.
- R2: A read is accepted on a clock edge where `req_valid`=1, `req_ready`=1 and `req_write`=0. From that edge, chip select and output enable are low and write enable is high for RD clocks. RD is the largest of ceil(T_AA/CLK), ceil(T_RC/CLK) and ceil(T_OE/CLK), which is 9 at the defaults. The bus is sampled at the last of these edges. `rsp_valid` then pulses with that byte, RD cycles after acceptance.
- R3: An accepted write (`req_write`=1) holds chip select and write enable low together, with output enable high, for WR clocks. WR is the largest of ceil(T_WP/CLK), ceil(T_CW/CLK), ceil(T_AW/CLK) and ceil(T_DW/CLK), which is 7 at the defaults. During this interval the requested byte is driven, and the bus is driven at no other time.
- R4: When write enable rises, chip select stays low and the bus is released for TAIL clocks. TAIL is ceil(T_WC/CLK) minus WR when that is positive, and 1 otherwise. It is 2 at the defaults.
- R5: The memory address does not change while chip select stays low.
- R6: The driven write byte does not change while write enable stays low.
- R7: Output enable is never low in a cycle where the bus is driven or was driven in the cycle before.
- R8: `req_ready` is 0 whenever chip select is low. A request held through a busy period is taken exactly once.
- R9: `rsp_valid` is a single-cycle pulse, issued exactly once per accepted read.
- R10: Every access keeps chip select low for at least ceil(T_RC/CLK) or ceil(T_WC/CLK) clocks, whichever applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Sequencer idle, request taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read byte valid, one cycle |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 19 | Address to memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_o | output | 8 | Byte to drive onto the data bus |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | 8 | Byte read from the data bus |

## Verification
The memory model in the bench returns a poison byte (0xEE) until output enable and the address have been steady for the read minimum. A read phase that is one clock too short therefore shows up as wrong data, not as a timing note. Writes go to address 0, to the top address and to scattered addresses, with data 0x00, 0xFF and alternating bit patterns. They are then read back, so a decoding error or a stuck data bit makes the bytes disagree. A read of a never-written location, an overwrite that is read back at once, and write-then-read pairs exercise the bus hand-over between accesses. Each overlap, tail and chip-select interval is measured in clocks against the minimums.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD   = 2'd1,
      ST_WR   = 2'd2,
      ST_TAIL = 2'd3
   } seq_state_e;

   // round a nanosecond minimum up to clocks, never below one clock
   function automatic int unsigned ns_to_clk(input int unsigned t_ns, input int unsigned clk_ns);
      int unsigned c;
      c = (t_ns + clk_ns - 1) / clk_ns;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             last
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
   import sram_seq_pkg::*;
#(
   parameter int unsigned CNT_W     = 4,
   parameter int unsigned RD_CLKS   = 9,
   parameter int unsigned WR_CLKS   = 7,
   parameter int unsigned TAIL_CLKS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic             tmr_last,
   output logic             req_ready,
   output logic             accept,
   output logic             capture,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output logic             cs_n,
   output logic             oe_n,
   output logic             we_n,
   output logic             dq_oe
);
   seq_state_e state_q, state_d;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_ready && req_valid;

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      capture  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (req_valid) begin
               tmr_load = 1'b1;
               if (req_write) begin
                  state_d = ST_WR;
                  tmr_val = CNT_W'(WR_CLKS);
               end else begin
                  state_d = ST_RD;
                  tmr_val = CNT_W'(RD_CLKS);
               end
            end
         end
         ST_RD: begin
            if (tmr_last) begin
               state_d = ST_IDLE;
               capture = 1'b1;
            end
         end
         ST_WR: begin
            if (tmr_last) begin
               state_d  = ST_TAIL;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(TAIL_CLKS);
            end
         end
         ST_TAIL: begin
            if (tmr_last) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   // strobes are registered from the next state so the pins never glitch
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cs_n    <= 1'b1;
         oe_n    <= 1'b1;
         we_n    <= 1'b1;
         dq_oe   <= 1'b0;
      end else begin
         state_q <= state_d;
         cs_n    <= (state_d == ST_IDLE);
         oe_n    <= (state_d != ST_RD);
         we_n    <= (state_d != ST_WR);
         dq_oe   <= (state_d == ST_WR);
      end
   end
endmodule

// File: rtl/sram_seq_dpath.sv
module sram_seq_dpath #(
   parameter int unsigned ADDR_W = 19,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              capture,
   input  logic [DATA_W-1:0] mem_dq_i,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_addr  <= '0;
         mem_dq_o  <= '0;
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         if (accept) begin
            mem_addr <= req_addr;
            if (req_write) mem_dq_o <= req_wdata;
         end
         rsp_valid <= capture;
         if (capture) rsp_rdata <= mem_dq_i;
      end
   end
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
   import sram_seq_pkg::*;
#(
   parameter int unsigned ADDR_W  = 19,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned CLK_NS  = 10,
   parameter int unsigned T_RC_NS = 85,
   parameter int unsigned T_AA_NS = 85,
   parameter int unsigned T_OE_NS = 40,
   parameter int unsigned T_WC_NS = 85,
   parameter int unsigned T_WP_NS = 55,
   parameter int unsigned T_CW_NS = 70,
   parameter int unsigned T_AW_NS = 70,
   parameter int unsigned T_DW_NS = 35
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_i
);
   localparam int unsigned RC_C = ns_to_clk(T_RC_NS, CLK_NS);
   localparam int unsigned AA_C = ns_to_clk(T_AA_NS, CLK_NS);
   localparam int unsigned OE_C = ns_to_clk(T_OE_NS, CLK_NS);
   localparam int unsigned WC_C = ns_to_clk(T_WC_NS, CLK_NS);
   localparam int unsigned WP_C = ns_to_clk(T_WP_NS, CLK_NS);
   localparam int unsigned CW_C = ns_to_clk(T_CW_NS, CLK_NS);
   localparam int unsigned AW_C = ns_to_clk(T_AW_NS, CLK_NS);
   localparam int unsigned DW_C = ns_to_clk(T_DW_NS, CLK_NS);

   localparam int unsigned RD_CLKS   = max2(max2(AA_C, RC_C), OE_C);
   localparam int unsigned WR_CLKS   = max2(max2(WP_C, CW_C), max2(AW_C, DW_C));
   localparam int unsigned TAIL_CLKS = (WC_C > WR_CLKS) ? (WC_C - WR_CLKS) : 1;
   localparam int unsigned CYC_CLKS  = (RD_CLKS < WR_CLKS + TAIL_CLKS) ? RD_CLKS : (WR_CLKS + TAIL_CLKS);
   localparam int unsigned CNT_MAX   = max2(max2(RD_CLKS, WR_CLKS), TAIL_CLKS);
   localparam int unsigned CNT_W     = $clog2(CNT_MAX + 1);

   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("sram_seq_ctrl: address and data widths must be at least 1");
   end
   if (CLK_NS < 1) begin : g_bad_clk
      $error("sram_seq_ctrl: clock period must be at least 1 ns");
   end
   if (CNT_W > 16) begin : g_bad_cnt
      $error("sram_seq_ctrl: timing minimums too long for the phase counter");
   end

   logic             accept;
   logic             capture;
   logic             tmr_load;
   logic             tmr_last;
   logic [CNT_W-1:0] tmr_val;

   sram_seq_fsm #(
      .CNT_W     (CNT_W),
      .RD_CLKS   (RD_CLKS),
      .WR_CLKS   (WR_CLKS),
      .TAIL_CLKS (TAIL_CLKS)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .tmr_last  (tmr_last),
      .req_ready (req_ready),
      .accept    (accept),
      .capture   (capture),
      .tmr_load  (tmr_load),
      .tmr_val   (tmr_val),
      .cs_n      (mem_cs_n),
      .oe_n      (mem_oe_n),
      .we_n      (mem_we_n),
      .dq_oe     (mem_dq_oe)
   );

   sram_seq_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .last     (tmr_last)
   );

   sram_seq_dpath #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_dpath (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .capture   (capture),
      .mem_dq_i  (mem_dq_i),
      .mem_addr  (mem_addr),
      .mem_dq_o  (mem_dq_o),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );
endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk #(
   parameter int unsigned ADDR_W   = 19,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned WR_CLKS  = 7,
   parameter int unsigned CYC_CLKS = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_cs_n,
   input logic              mem_oe_n,
   input logic              mem_we_n,
   input logic [DATA_W-1:0] mem_dq_o,
   input logic              mem_dq_oe
);
   localparam logic [15:0] WR_MIN  = 16'(WR_CLKS);
   localparam logic [15:0] CYC_MIN = 16'(CYC_CLKS);

   logic [15:0] we_run;
   logic [15:0] cs_run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         we_run <= '0;
         cs_run <= '0;
      end else begin
         we_run <= mem_we_n ? 16'd0 : ((we_run == 16'hFFFF) ? we_run : we_run + 16'd1);
         cs_run <= mem_cs_n ? 16'd0 : ((cs_run == 16'hFFFF) ? cs_run : cs_run + 16'd1);
      end
   end

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe));

   a_r2_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (!mem_cs_n && mem_we_n));

   a_r3_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (!mem_we_n && !mem_cs_n && mem_oe_n));

   a_r3_write_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_run >= WR_MIN));

   a_r4_tail_cs_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (!mem_cs_n && !mem_dq_oe));

   a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));

   a_r6_wdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n && !$past(mem_we_n)) |-> $stable(mem_dq_o));

   a_r7_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> !$past(mem_dq_oe));

   a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_cs_n |-> !req_ready);

   a_r9_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   a_r9_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !$past(mem_oe_n));

   a_r10_cycle_len: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_cs_n) |-> (cs_run >= CYC_MIN));
endmodule

bind sram_seq_ctrl sram_seq_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .WR_CLKS  (WR_CLKS),
   .CYC_CLKS (CYC_CLKS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .mem_addr  (mem_addr),
   .mem_cs_n  (mem_cs_n),
   .mem_oe_n  (mem_oe_n),
   .mem_we_n  (mem_we_n),
   .mem_dq_o  (mem_dq_o),
   .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_seq_ctrl_tb.sv
module sram_seq_ctrl_tb;
   localparam int CLK_NS   = 10;
   localparam int HALF     = CLK_NS / 2;
   localparam int B_RC     = (85 + CLK_NS - 1) / CLK_NS;
   localparam int B_AA     = (85 + CLK_NS - 1) / CLK_NS;
   localparam int B_OE     = (40 + CLK_NS - 1) / CLK_NS;
   localparam int B_WC     = (85 + CLK_NS - 1) / CLK_NS;
   localparam int B_WP     = (55 + CLK_NS - 1) / CLK_NS;
   localparam int B_CW     = (70 + CLK_NS - 1) / CLK_NS;
   localparam int B_RD     = (B_RC > B_AA) ? ((B_RC > B_OE) ? B_RC : B_OE) : ((B_AA > B_OE) ? B_AA : B_OE);
   localparam int B_WR     = (B_WP > B_CW) ? B_WP : B_CW;
   localparam int B_TAIL   = (B_WC > B_WR) ? (B_WC - B_WR) : 1;
   localparam int B_CYC    = (B_RD < B_WR + B_TAIL) ? B_RD : (B_WR + B_TAIL);

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [18:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        rsp_valid;
   logic [7:0]  rsp_rdata;
   logic [18:0] mem_addr;
   logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [7:0]  mem_dq_o;
   logic [7:0]  mem_dq_i = 8'hEE;

   int n_checks = 0;
   int n_err    = 0;
   int cyc      = 0;
   bit done     = 0;

   logic [7:0] ref_mem   [int];
   logic [7:0] model_mem [int];
   logic [7:0] exp_q [$];
   int         acc_q [$];

   sram_seq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
      .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
   );

   always #HALF clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   endtask

   // memory model and strobe monitor, all at the falling edge
   bit          prev_ov = 0, prev_cs_low = 0, prev_dq_oe = 0, prev_rsp = 0, in_tail = 0;
   logic [18:0] prev_addr = '0, wr_addr = '0;
   logic [7:0]  prev_data = '0, wr_data = '0;
   int          wr_len = 0, tail_len = 0, cs_len = 0, rd_age = 0, addr_age = 0;

   always @(negedge clk) begin
      bit ov, cs_low;
      if (rst_n) begin
         ov     = !mem_cs_n && !mem_we_n;
         cs_low = !mem_cs_n;
         // R1 idle quiet
         if (req_ready)
            chk(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1 idle strobes",
                {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
         // R8 busy means not ready
         if (cs_low) chk(!req_ready, "R8 ready while busy", req_ready, 0);
         // R7 bus released before output enable
         if (!mem_oe_n) chk(!mem_dq_oe && !prev_dq_oe, "R7 drive near read",
                            {prev_dq_oe, mem_dq_oe}, 0);
         // R5 address stable
         if (cs_low && prev_cs_low) chk(mem_addr == prev_addr, "R5 address moved", mem_addr, prev_addr);
         // R3 / R6 write overlap
         if (ov) begin
            chk(mem_dq_oe && mem_oe_n, "R3 overlap drive", {mem_dq_oe, mem_oe_n}, 2'b11);
            if (prev_ov) chk(mem_dq_o == prev_data, "R6 write data moved", mem_dq_o, prev_data);
            wr_len++;
            wr_addr = mem_addr;
            wr_data = mem_dq_o;
         end else if (mem_dq_oe) begin
            chk(0, "R3 drive outside write", 1, 0);
         end
         if (prev_ov && !ov) begin
            chk(wr_len == B_WR, "R3 overlap length", wr_len, B_WR);
            model_mem[int'(wr_addr)] = wr_data;
            wr_len   = 0;
            in_tail  = 1;
            tail_len = 0;
         end
         // R4 tail
         if (in_tail) begin
            if (cs_low) begin
               tail_len++;
               chk(!mem_dq_oe && mem_we_n, "R4 tail released", mem_dq_oe, 0);
            end else begin
               chk(tail_len == B_TAIL, "R4 tail length", tail_len, B_TAIL);
               in_tail = 0;
            end
         end
         // R10 access length
         if (cs_low) cs_len++;
         else if (prev_cs_low) begin
            chk(cs_len >= B_CYC, "R10 access too short", cs_len, B_CYC);
            cs_len = 0;
         end
         // read model: poison until the read minimum has elapsed
         addr_age = (mem_addr != prev_addr) ? 1 : addr_age + 1;
         rd_age   = (cs_low && !mem_oe_n && mem_we_n) ? rd_age + 1 : 0;
         if (rd_age >= B_RD && addr_age >= B_AA)
            mem_dq_i <= model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 8'h00;
         else
            mem_dq_i <= 8'hEE;
         // R2 / R9 scoreboard
         if (rsp_valid) begin
            chk(!prev_rsp, "R9 response longer than one cycle", 1, 0);
            if (exp_q.size() == 0) chk(0, "R9 unexpected response", rsp_rdata, 0);
            else begin
               logic [7:0] e;
               int         a;
               e = exp_q.pop_front();
               a = acc_q.pop_front();
               chk(rsp_rdata == e, "R2 read data", rsp_rdata, e);
               chk(cyc - a == B_RD, "R2 read latency", cyc - a, B_RD);
            end
         end
         prev_ov     = ov;
         prev_cs_low = cs_low;
         prev_addr   = mem_addr;
         prev_data   = mem_dq_o;
         prev_dq_oe  = mem_dq_oe;
         prev_rsp    = rsp_valid;
      end
   end

   task automatic issue(input bit wr, input logic [18:0] a, input logic [7:0] d);
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = a;
      req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      #1;
      if (wr) ref_mem[int'(a)] = d;
      else begin
         exp_q.push_back(ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00);
         acc_q.push_back(cyc);
      end
      @(negedge clk);
      req_valid = 1'b0;
      req_wdata = 8'h99;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid, "R1 reset state",
          {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_valid}, 5'b11100);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);

      issue(1, 19'h00000, 8'hA5);
      issue(1, 19'h7FFFF, 8'h5A);
      issue(1, 19'h12345, 8'hFF);
      issue(1, 19'h00100, 8'h00);
      issue(0, 19'h00000, 8'h00);
      issue(0, 19'h7FFFF, 8'h00);
      issue(0, 19'h12345, 8'h00);
      issue(0, 19'h00100, 8'h00);
      issue(0, 19'h02222, 8'h00);   // never written: reads 0x00
      issue(1, 19'h00000, 8'h3C);   // overwrite then immediate read
      issue(0, 19'h00000, 8'h00);
      issue(0, 19'h7FFFF, 8'h00);   // read followed by write
      issue(1, 19'h7FFFF, 8'hC3);
      issue(0, 19'h7FFFF, 8'h00);
      for (int i = 0; i < 16; i++)
         issue(1, 19'((i * 32'h1357B) ^ (i << 15)), 8'((i * 37 + 11) ^ 8'h55));
      for (int i = 15; i >= 0; i--)
         issue(0, 19'((i * 32'h1357B) ^ (i << 15)), 8'h00);

      repeat (3 * B_RD) @(negedge clk);
      chk(exp_q.size() == 0, "R9 every read answered", exp_q.size(), 0);
      done = 1;
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_err++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
         finish_run();
      end
   end
endmodule